// File: doc/BRIEF.md
# Interleaved I/Q Double-Data-Rate DAC Transmitter

This block sits between a baseband transmit path and a DAC with a single 16-bit data port. It accepts one complex sample per clock through a valid/ready handshake: a 16-bit in-phase word and a 16-bit quadrature word, both two's complement. It sends both words over one bus. The in-phase word is driven while the clock is high and the quadrature word while it is low.

The output stage is written in plain logic. It behaves like a same-edge double-data-rate output register. A rising edge captures both words of a pair together, and a multiplexer driven by the clock level then puts one word on the bus in each half of the cycle. A second cell of the same kind, fed with constant one and constant zero, produces the forwarded data clock. Clock and data therefore pass through matching logic, and no deskew or feedback is applied to the clock.

When no sample is offered, the block sends zero on both halves. In test mode the sample input is refused. The block then sends a counter ramp as the in-phase word and the bitwise inverse of that ramp as the quadrature word, so a receiver can confirm which edge carries which channel. The frame output is held low at all times.

Top module: `iq_ddr_tx`

## Requirements
- R1: While reset is asserted (rst_n low), dac_data is 0, dac_clk is 0 in both clock phases, and s_ready is 0.
- R2: From the second rising edge after reset release, s_ready is 1 exactly when test_en is 0. While test_en is 1, s_ready is 0.
- R3: A sample accepted at a rising edge (s_valid and s_ready both 1) puts its s_i word on dac_data during the high phase that follows that edge.
- R4: The s_q word of the same accepted sample is on dac_data during the low phase of that same cycle.
- R5: When test_en is 0 and no sample is accepted at a rising edge, dac_data is 0 in both phases of the following cycle.
- R6: When test_en is 1 at a rising edge, s_valid, s_i and s_q are ignored. The high phase carries the ramp value and the low phase carries its bitwise inverse. The ramp is 0 after reset, advances by one after each test cycle, and holds its value while test_en is 0.
- R7: After reset release, dac_clk is 1 during every high phase and 0 during every low phase of clk.
- R8: dac_frame is 0 at all times.
- R9: Words pass through bit-exact, including the two's-complement extremes 16'h8000 and 16'h7FFF, and 16'hFFFF (minus one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Selects the ramp test pattern |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample will be taken at the next rising edge |
| s_i | input | 16 | In-phase word, two's complement |
| s_q | input | 16 | Quadrature word, two's complement |
| dac_data | output | 16 | Interleaved bus: I in the high phase, Q in the low phase |
| dac_clk | output | 1 | Forwarded data clock |
| dac_frame | output | 1 | Frame strobe, held low |

## Verification
The assertions take for granted that s_valid, s_i, s_q and test_en change only away from the rising edge, and that rst_n is released while clk is low. They also assume that test_en may switch on any cycle, with no link to the handshake. The bench changes every input three quarters of the way through a cycle and releases reset at that same point. It moves between data, idle and test cycles freely, so each assertion is triggered on the path it guards. The bench also holds s_valid high with non-zero words during test cycles, to show that test mode ignores them.

// File: rtl/iq_tx_pkg.sv
package iq_tx_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_DATA = 2'd1,
    SRC_TEST = 2'd2
  } src_sel_e;
endpackage

// File: rtl/iq_ddr_cell.sv
// Same-edge DDR output model: both words latched on the rising edge,
// then the clock level selects which one reaches the pin.
module iq_ddr_cell #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_rise,
  input  logic [W-1:0] d_fall,
  output logic [W-1:0] cap_rise,
  output logic [W-1:0] cap_fall,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rise <= '0;
      cap_fall <= '0;
    end else begin
      cap_rise <= d_rise;
      cap_fall <= d_fall;
    end
  end

  // half-rate multiplex: high phase shows the rise word
  always_comb q = clk ? cap_rise : cap_fall;
endmodule

// File: rtl/iq_tx_source.sv
module iq_tx_source
  import iq_tx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         test_en,
  input  logic         s_valid,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] s_q,
  output logic         s_ready,
  output src_sel_e     sel,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic [W-1:0] ramp_q;

  function automatic logic [W-1:0] ramp_partner(input logic [W-1:0] v);
    return ~v;
  endfunction

  function automatic logic [W-1:0] ramp_step(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign s_ready = run && !test_en;

  always_comb begin
    if (run && test_en)         sel = SRC_TEST;
    else if (s_ready && s_valid) sel = SRC_DATA;
    else                         sel = SRC_IDLE;
  end

  always_comb begin
    unique case (sel)
      SRC_DATA: begin nxt_hi = s_i;    nxt_lo = s_q;                  end
      SRC_TEST: begin nxt_hi = ramp_q; nxt_lo = ramp_partner(ramp_q); end
      default:  begin nxt_hi = '0;     nxt_lo = '0;                   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ramp_q <= '0;
    else if (sel == SRC_TEST) ramp_q <= ramp_step(ramp_q);
  end

  assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_TEST) |=> (ramp_q == ramp_step($past(ramp_q))));

  assert_ramp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SRC_TEST) |=> $stable(ramp_q));

  assert_ready_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> !s_ready);
endmodule

// File: rtl/iq_ddr_tx.sv
module iq_ddr_tx
  import iq_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_en,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_i,
  input  logic [SAMPLE_W-1:0] s_q,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_clk,
  output logic                dac_frame
);
  localparam int unsigned CLK_W = 1;

  logic                run_q;
  src_sel_e            sel;
  logic [SAMPLE_W-1:0] nxt_hi, nxt_lo;
  logic [SAMPLE_W-1:0] data_rise, data_fall;
  logic [CLK_W-1:0]    ck_rise, ck_fall, ck_q;
  logic [CLK_W-1:0]    ck_one, ck_zero;

  // event wires for the assertions
  logic accept_evt, test_evt, idle_evt;
  assign accept_evt = (sel == SRC_DATA);
  assign test_evt   = (sel == SRC_TEST);
  assign idle_evt   = (sel == SRC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  iq_tx_source #(.W(SAMPLE_W)) src_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .test_en (test_en),
    .s_valid (s_valid),
    .s_i     (s_i),
    .s_q     (s_q),
    .s_ready (s_ready),
    .sel     (sel),
    .nxt_hi  (nxt_hi),
    .nxt_lo  (nxt_lo)
  );

  iq_ddr_cell #(.W(SAMPLE_W)) data_cell_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_rise   (nxt_hi),
    .d_fall   (nxt_lo),
    .cap_rise (data_rise),
    .cap_fall (data_fall),
    .q        (dac_data)
  );

  // forwarded clock: same cell type, constant 1 on rise and 0 on fall
  assign ck_one  = {CLK_W{1'b1}};
  assign ck_zero = {CLK_W{1'b0}};

  iq_ddr_cell #(.W(CLK_W)) clk_cell_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_rise   (ck_one),
    .d_fall   (ck_zero),
    .cap_rise (ck_rise),
    .cap_fall (ck_fall),
    .q        (ck_q)
  );

  assign dac_clk   = ck_q[0];
  assign dac_frame = 1'b0;

  assert_accept_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (data_rise == $past(s_i)));

  assert_accept_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (data_fall == $past(s_q)));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> (data_rise == '0 && data_fall == '0));

  assert_test_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_evt |=> (data_fall == ~data_rise));

  assert_clk_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ck_rise == 1'b1 && ck_fall == 1'b0));
endmodule

// File: tb/iq_ddr_tx_tb_top.sv
module iq_ddr_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_en = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_i = '0, s_q = '0;
  logic [15:0] dac_data;
  logic        dac_clk, dac_frame;

  int checks = 0;
  int failures = 0;
  logic [15:0] ramp_m = '0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  iq_ddr_tx dut_i (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .s_valid(s_valid),
    .s_ready(s_ready), .s_i(s_i), .s_q(s_q), .dac_data(dac_data),
    .dac_clk(dac_clk), .dac_frame(dac_frame)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at 3/4 of a cycle: drive inputs, predict, then receive both halves.
  task automatic tick(input bit v, input logic [15:0] i, input logic [15:0] q,
                      input bit t, input string req);
    logic [15:0] ei, eq;
    s_valid = v; s_i = i; s_q = q; test_en = t;
    if (t) begin
      ei = ramp_m; eq = ~ramp_m; ramp_m = ramp_m + 16'd1;
    end else if (v) begin
      ei = i; eq = q;
    end else begin
      ei = '0; eq = '0;
    end
    #1;
    chk("R2 s_ready", {15'd0, s_ready}, {15'd0, ~t});
    @(posedge clk);
    #2;
    chk({req, " hi"}, dac_data, ei);
    chk("R7 clk high", {15'd0, dac_clk}, 16'd1);
    chk("R8 frame", {15'd0, dac_frame}, 16'd0);
    #4;
    chk({req, " lo"}, dac_data, eq);
    chk("R7 clk low", {15'd0, dac_clk}, 16'd0);
  endtask

  initial begin
    // R1: reset state in both phases
    repeat (3) @(posedge clk);
    #2;
    chk("R1 data hi", dac_data, 16'd0);
    chk("R1 clk hi", {15'd0, dac_clk}, 16'd0);
    chk("R1 ready", {15'd0, s_ready}, 16'd0);
    s_valid = 1'b1; s_i = 16'h1234; s_q = 16'h5678;
    #4;
    chk("R1 data lo", dac_data, 16'd0);
    chk("R8 frame reset", {15'd0, dac_frame}, 16'd0);
    rst_n = 1'b1;   // released while clk low
    s_valid = 1'b0;
    @(posedge clk);
    #6;
    // R9 extremes
    tick(1, 16'h8000, 16'h7FFF, 0, "R9 R3 R4 min/max");
    tick(1, 16'h7FFF, 16'h8000, 0, "R9 R3 R4 max/min");
    tick(1, 16'hFFFF, 16'h0001, 0, "R9 R3 R4 -1/+1");
    tick(0, 16'hDEAD, 16'hBEEF, 0, "R5 idle");
    // sweep with periodic idle
    for (int k = 0; k < 48; k++) begin
      logic [15:0] a, b;
      a = 16'(k * 16'h1357) ^ 16'hA5A5;
      b = ~16'(k * 16'h0B3D);
      if (k % 5 == 4) tick(0, a, b, 0, "R5 idle gap");
      else            tick(1, a, b, 0, "R3 R4 stream");
    end
    // test mode, valid held high with live data (ignored)
    for (int k = 0; k < 20; k++)
      tick(1, 16'(k + 16'h4000), 16'hCAFE, 1, "R6 ramp");
    tick(1, 16'h0F0F, 16'hF0F0, 0, "R3 R4 after test");
    tick(0, 16'h0, 16'h0, 0, "R5 idle after test");
    // ramp resumes where it stopped
    for (int k = 0; k < 6; k++)
      tick(0, 16'h1111, 16'h2222, 1, "R6 ramp resume");
    tick(1, 16'h0000, 16'h0000, 0, "R9 zero word");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule